// File: doc/BRIEF.md
# Clock-Run Stop Arbiter

This block is the device-side participant in the bus clock-run handshake. The clock-run line is shared, active low and open drain: a pull-up holds it high unless some agent pulls it low. The host holds the line low while the bus clock must run. When the host lets the line rise, it is asking to stop the bus clock. The block either lets that stop happen or vetoes it by pulling the line low again. It vetoes whenever any keep-alive condition holds. Those conditions are a software keep-clock control bit, a busy flag from the 16-bit card resource manager, a busy flag from the card-bus master sequencer, pending posted data in the bus master, any pending interrupt, and a running card clock on any socket.

When the bus clock has already been stopped and a keep-alive condition appears, the block pulls the line low to ask for a restart. It holds that drive until the clock is reported running again. Generation of the per-socket card clock-run is outside this block; the socket clocks' "still running" flags arrive as inputs. The block runs on a free-running local sampling clock `clk`. It is told by `bus_clk_live` whether the bus clock is currently toggling, and that input is assumed to be already synchronous to `clk`.

The block only ever enables an active-low driver. It never drives the line high. All inputs and outputs are plain level control pins, so there is no valid/ready flow and no back-pressure to define.

Top module: `clkrun_arbiter`

## Requirements
- R1: While `rst_n` is low, `cr_pull_en` is 0. Immediately after reset is released, `cr_pull_en` is also 0.
- R2: When `keep_clk` is 1 and the line (`cr_line_n`) rises with the bus clock live, `cr_pull_en` becomes 1 within two `clk` cycles of the line going high.
- R3: `res16_busy` at 1 vetoes a stop request in the same way as R2.
- R4: `cbm_busy` at 1 vetoes a stop request in the same way as R2.
- R5: `posted_pend` at 1 vetoes a stop request in the same way as R2.
- R6: Any bit of `irq_pend` at 1 vetoes a stop request in the same way as R2.
- R7: Any bit of `sock_clk_on` at 1 vetoes a stop request in the same way as R2.
- R8: A veto drive lasts exactly `VETO_CYCLES` cycles. After that the driver is released (`cr_pull_en` = 0).
- R9: If no keep-alive condition holds, a stop request is not vetoed: `cr_pull_en` stays 0 while the line is high.
- R10: While `bus_clk_live` is 0, a keep-alive condition pulls the line low. The drive starts two cycles after the condition is raised and holds until `bus_clk_live` returns to 1. It is released on the first clock edge that sees the bus clock live.
- R11: While the host holds the line low and the bus clock is live, `cr_pull_en` stays 0 whatever the keep-alive inputs are.
- R12: The keep-alive inputs are merged by OR into a single register, so a keep-alive input takes effect at the second rising edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_line_n | input | 1 | Sampled level of the shared clock-run line (1 = high) |
| bus_clk_live | input | 1 | 1 while the bus clock is toggling |
| keep_clk | input | 1 | Software keep-clock control bit |
| res16_busy | input | 1 | 16-bit card resource manager busy |
| cbm_busy | input | 1 | Card-bus master sequencer busy |
| posted_pend | input | 1 | Posted data waiting in the bus master |
| irq_pend | input | NUM_IRQ | Pending interrupt flags |
| sock_clk_on | input | NUM_SOCK | Per-socket card clock still running |
| cr_pull_en | output | 1 | Enables the open-drain pull-low on the clock-run line |

## Verification
The bench builds the block with `VETO_CYCLES` = 3, `NUM_IRQ` = 4 and `NUM_SOCK` = 2. With these values the veto window spans several cycles, so the bench can observe both its exact start and its exact end. The bench also tries interrupt and socket bits other than bit 0, which shows that every vector bit reaches the merge. It models the wired line as the AND of the host's release and the block's release. This lets the bench run the release–veto–re-assert cycle, a permitted stop, and a clock-restart request while the clock is held stopped.

// File: rtl/clkrun_pkg.sv
package clkrun_pkg;
  typedef enum logic [1:0] {
    CR_IDLE    = 2'd0,
    CR_VETO    = 2'd1,
    CR_RESTART = 2'd2
  } cr_state_e;
endpackage

// File: rtl/clkrun_keepalive.sv
module clkrun_keepalive #(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_SOCK = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                keep_clk,
  input  logic                res16_busy,
  input  logic                cbm_busy,
  input  logic                posted_pend,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  input  logic [NUM_SOCK-1:0] sock_clk_on,
  output logic                alive_q
);
  localparam int NUM_SRC = 4 + NUM_IRQ + NUM_SOCK;

  logic [NUM_SRC-1:0] src;

  assign src[0] = keep_clk;
  assign src[1] = res16_busy;
  assign src[2] = cbm_busy;
  assign src[3] = posted_pend;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
    assign src[4+gi] = irq_pend[gi];
  end
  for (genvar gs = 0; gs < NUM_SOCK; gs++) begin : g_sock
    assign src[4+NUM_IRQ+gs] = sock_clk_on[gs];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive_q <= 1'b0;
    else        alive_q <= |src;
  end

  // R6
  irq_reaches_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pend) |=> alive_q);

  // R7
  sock_reaches_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sock_clk_on) |=> alive_q);
endmodule

// File: rtl/clkrun_fsm.sv
module clkrun_fsm
  import clkrun_pkg::*;
#(
  parameter int VETO_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cr_line_n,
  input  logic bus_clk_live,
  input  logic alive_q,
  output logic cr_pull_en
);
  localparam int CNT_W = (VETO_CYCLES < 2) ? 1 : $clog2(VETO_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(VETO_CYCLES - 1);

  cr_state_e        state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= cr_line_n;
  end

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    unique case (state)
      CR_IDLE: begin
        if (alive_q && !bus_clk_live) begin
          state_nx = CR_RESTART;
        end else if (alive_q && line_q) begin
          state_nx = CR_VETO;
          cnt_nx   = CNT_LOAD;
        end
      end
      CR_VETO: begin
        if (cnt == '0) state_nx = CR_IDLE;
        else           cnt_nx   = cnt - 1'b1;
      end
      CR_RESTART: begin
        if (bus_clk_live) state_nx = CR_IDLE;
      end
      default: state_nx = CR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CR_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign cr_pull_en = (state == CR_VETO) || (state == CR_RESTART);

  // R8
  veto_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CR_VETO) |-> (cnt <= CNT_LOAD));

  // R10
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_pull_en && !bus_clk_live && state == CR_RESTART) |=> cr_pull_en);

  // R11
  drive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_pull_en && !$past(cr_pull_en)) |-> ($past(line_q) || !$past(bus_clk_live)));

  // R9
  no_alive_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alive_q && bus_clk_live && state == CR_IDLE) |=> !cr_pull_en);
endmodule

// File: rtl/clkrun_arbiter.sv
module clkrun_arbiter #(
  parameter int VETO_CYCLES = 2,
  parameter int NUM_IRQ     = 8,
  parameter int NUM_SOCK    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cr_line_n,
  input  logic                bus_clk_live,
  input  logic                keep_clk,
  input  logic                res16_busy,
  input  logic                cbm_busy,
  input  logic                posted_pend,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  input  logic [NUM_SOCK-1:0] sock_clk_on,
  output logic                cr_pull_en
);
  logic alive_q;

  clkrun_keepalive #(.NUM_IRQ(NUM_IRQ), .NUM_SOCK(NUM_SOCK)) u_alive (
    .clk         (clk),
    .rst_n       (rst_n),
    .keep_clk    (keep_clk),
    .res16_busy  (res16_busy),
    .cbm_busy    (cbm_busy),
    .posted_pend (posted_pend),
    .irq_pend    (irq_pend),
    .sock_clk_on (sock_clk_on),
    .alive_q     (alive_q)
  );

  clkrun_fsm #(.VETO_CYCLES(VETO_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cr_line_n    (cr_line_n),
    .bus_clk_live (bus_clk_live),
    .alive_q      (alive_q),
    .cr_pull_en   (cr_pull_en)
  );
endmodule

// File: tb/clkrun_arbiter_bench.sv
module clkrun_arbiter_bench;
  localparam int V  = 3;
  localparam int NI = 4;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_low = 1'b1;
  logic          bus_clk_live = 1'b1;
  logic          keep_clk = 1'b0, res16_busy = 1'b0, cbm_busy = 1'b0, posted_pend = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic [NS-1:0] sock_clk_on = '0;
  logic          cr_pull_en;
  logic          cr_line_n;

  int  cyc = 0;
  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  typedef struct {
    int    at;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  assign cr_line_n = !(host_low || cr_pull_en);

  clkrun_arbiter #(.VETO_CYCLES(V), .NUM_IRQ(NI), .NUM_SOCK(NS)) u_clkrun_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .cr_line_n    (cr_line_n),
    .bus_clk_live (bus_clk_live),
    .keep_clk     (keep_clk),
    .res16_busy   (res16_busy),
    .cbm_busy     (cbm_busy),
    .posted_pend  (posted_pend),
    .irq_pend     (irq_pend),
    .sock_clk_on  (sock_clk_on),
    .cr_pull_en   (cr_pull_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int at, bit val, string tag);
    exp_t e;
    e.at = at; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check_now(bit val, string tag);
    n_vec++;
    if (cr_pull_en !== val) begin
      n_bad++;
      $display("FAIL %s: cr_pull_en=%0b expected %0b (cycle %0d)", tag, cr_pull_en, val, cyc);
    end
  endtask

  // monitor: pops expectations due at the current cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      check_now(e.val, e.tag);
    end
  end

  task automatic set_src(int sel, bit v);
    case (sel)
      0: keep_clk    = v;
      1: res16_busy  = v;
      2: cbm_busy    = v;
      3: posted_pend = v;
      4: irq_pend[2] = v;
      5: sock_clk_on[1] = v;
      6: irq_pend[0] = v;
      default: sock_clk_on[0] = v;
    endcase
  endtask

  // host releases the line with one keep-alive source raised
  task automatic veto_case(int sel, string tag);
    int c;
    @(negedge clk);
    set_src(sel, 1'b1);
    repeat (2) @(negedge clk);
    c = cyc;
    host_low = 1'b0;
    push(c + 1, 1'b0, tag);
    for (int i = 2; i <= V + 1; i++) push(c + i, 1'b1, tag);
    push(c + V + 2, 1'b0, "R8");
    repeat (V + 2) @(negedge clk);
    host_low = 1'b1;
    set_src(sel, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check_now(1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_now(1'b0, "R1");

    veto_case(0, "R2");
    veto_case(1, "R3");
    veto_case(2, "R4");
    veto_case(3, "R5");
    veto_case(4, "R6");
    veto_case(6, "R6");
    veto_case(5, "R7");
    veto_case(7, "R7");

    // R11: host holds line low, keep-alive present
    @(negedge clk);
    keep_clk = 1'b1;
    cbm_busy = 1'b1;
    c = cyc;
    for (int i = 1; i <= 6; i++) push(c + i, 1'b0, "R11");
    repeat (7) @(negedge clk);
    keep_clk = 1'b0;
    cbm_busy = 1'b0;
    repeat (3) @(negedge clk);

    // R9: release with nothing alive -> stop allowed
    c = cyc;
    host_low = 1'b0;
    for (int i = 1; i <= 5; i++) push(c + i, 1'b0, "R9");
    repeat (5) @(negedge clk);
    bus_clk_live = 1'b0;
    repeat (2) @(negedge clk);
    c = cyc;
    push(c, 1'b0, "R9");

    // R10 / R12: activity while clock stopped
    @(negedge clk);
    c = cyc;
    res16_busy = 1'b1;
    push(c + 1, 1'b0, "R12");
    for (int i = 2; i <= 6; i++) push(c + i, 1'b1, "R10");
    repeat (6) @(negedge clk);
    bus_clk_live = 1'b1;
    host_low = 1'b1;
    push(c + 7, 1'b0, "R10");
    push(c + 8, 1'b0, "R11");
    repeat (3) @(negedge clk);
    res16_busy = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule